// File: doc/BRIEF.md
# Graphics RAM block-write engine

This block is a small synchronous graphics memory with a command front end for frame-buffer fills and masked pixel updates. Each clock it takes one command. The commands load a fill color, load a per-bit write mask, write a word, fill a group of columns, read a word, or change the read latency. A fill writes the stored color into any subset of eight neighbouring columns in a single cycle. Columns whose enable bit is clear are not touched at all, so large screen clears take one command per eight words.

Every write, whether a single word or a group fill, passes through the same merge. Per-byte lane masks protect whole bytes. When the command asks for it, the stored bit mask also protects single bits. Protected bits keep their old value, and the block never needs a read cycle to merge them. Read data leaves through a short delay pipeline with a valid strobe. The delay is 1, 2 or 3 cycles, set by command.

The read output has no ready input and the command input has no back-pressure. The consumer must accept each rd_valid pulse in the cycle it appears. The command source may issue a command on every clock.

Top module: `gfx_gram`

## Requirements
- R1: After reset, rd_valid is low and the read latency is 2. The color register and the bit-mask register are all ones, and every array word reads as zero.
- R2: cmd_op encodes the command: 0 no-op, 1 load color from cmd_data, 2 load bit mask from cmd_data, 3 write, 4 group fill, 5 read, 6 set latency. Code 7 acts as a no-op. One command is taken per clock.
- R3: On a write, cmd_lane_mask bit b set to 1 keeps bits [8b+7:8b] of the addressed word unchanged. Bit 0 guards the low byte. Unmasked lanes take cmd_data.
- R4: When cmd_bitmask_en is 1 on a write or fill, only the bit positions that are 1 in the bit-mask register, and also lie in an unmasked lane, change. When cmd_bitmask_en is 0, the bit-mask register has no effect.
- R5: A group fill (op 4) clears the low 3 bits of cmd_addr to form the base. For each bit i of cmd_col_en that is 1, it writes the color register into word base+i, merged under R3 and R4. Words whose bit is 0 keep their content. All eight words update at the same clock edge.
- R6: Let a read be sampled at clock edge k and let the latency be L. Then rd_valid is high for exactly one cycle, the cycle after edge k+L-1, and rd_data then holds the addressed word.
- R7: Set latency (op 6) loads cmd_data as the new latency when its value is 1, 2 or 3. Any other value is ignored.
- R8: A latency change applies only to reads sampled after it. In-flight reads keep their delay. When an older read and a newer read would appear in the same cycle, the older one is delivered and the newer one is dropped.
- R9: A read issued in the cycle right after a write or fill to the same address returns the newly written value.
- R10: Reads may be issued on consecutive clocks. Their results then appear on consecutive cycles, in issue order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 8 | Word address (fill base after alignment) |
| cmd_data | input | 16 | Write data, register load value or latency |
| cmd_lane_mask | input | 2 | Per-byte write protect, 1 = keep |
| cmd_bitmask_en | input | 1 | Apply the bit-mask register to this write |
| cmd_col_en | input | 8 | Column enables for a group fill |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 16 | Read result |

## Verification
The bench builds the block with its default parameters: 256 words of 16 bits, eight-column fill groups and a maximum latency of 3. This size lets the bench sweep every address at each of the three latencies, every fill group with a varied set of column enables, and every lane-mask pattern, all checked against an arithmetic model of the merge. The small latency range also lets the bench reach both in-flight orderings after a latency change: two results one cycle apart, and a same-cycle collision.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'b000,
    OP_LDCOLOR = 3'b001,
    OP_LDMASK  = 3'b010,
    OP_WRITE   = 3'b011,
    OP_FILL    = 3'b100,
    OP_READ    = 3'b101,
    OP_SETLAT  = 3'b110
  } gfx_op_e;
endpackage

// File: rtl/gfx_merge.sv
module gfx_merge #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [NLANE-1:0]  lane_keep,
  input  logic [DATA_W-1:0] bit_mask,
  input  logic              bit_mask_en,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] lane_en;
  logic [DATA_W-1:0] change_en;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign lane_en[b*LANE_W +: LANE_W] = {LANE_W{~lane_keep[b]}};
  end

  assign change_en = bit_mask_en ? (lane_en & bit_mask) : lane_en;
  assign merged    = (old_word & ~change_en) | (new_word & change_en);
endmodule

// File: rtl/gfx_array.sv
module gfx_array #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int BLK_COLS = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int COL_W = $clog2(BLK_COLS),
  localparam int GRP_W = ADDR_W - COL_W,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_req,
  input  logic                blk_mode,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W-1:0]   color,
  input  logic [NLANE-1:0]    lane_keep,
  input  logic [DATA_W-1:0]   bit_mask,
  input  logic                bit_mask_en,
  input  logic [BLK_COLS-1:0] col_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  logic [GRP_W-1:0]    grp;
  logic [COL_W-1:0]    col;
  logic [DATA_W-1:0]   src;
  logic [BLK_COLS-1:0] slot_we;
  logic [DATA_W-1:0]   slot_old [BLK_COLS];
  logic [DATA_W-1:0]   slot_new [BLK_COLS];

  assign grp = wr_addr[ADDR_W-1:COL_W];
  assign col = wr_addr[COL_W-1:0];
  assign src = blk_mode ? color : wr_data;

  for (genvar c = 0; c < BLK_COLS; c++) begin : g_slot
    localparam logic [COL_W-1:0] CI = COL_W'(c);
    assign slot_old[c] = mem[{grp, CI}];
    assign slot_we[c]  = wr_req & (blk_mode ? col_en[c] : (col == CI));
    gfx_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
      .old_word    (slot_old[c]),
      .new_word    (src),
      .lane_keep   (lane_keep),
      .bit_mask    (bit_mask),
      .bit_mask_en (bit_mask_en),
      .merged      (slot_new[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      for (int c = 0; c < BLK_COLS; c++)
        if (slot_we[c]) mem[{grp, COL_W'(c)}] <= slot_new[c];
    end
  end

  assign rd_word = mem[rd_addr];

  logic [DATA_W-1:0] tgt_old;
  logic [ADDR_W-1:0] slot0_addr;
  assign tgt_old    = mem[wr_addr];
  assign slot0_addr = {grp, {COL_W{1'b0}}};

  // R3: a word write with both lanes protected leaves the word as it was
  a_r3_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !blk_mode && (&lane_keep)) |=> mem[$past(wr_addr)] == $past(tgt_old));

  // R5: a fill with column 0 disabled leaves the group's first word as it was
  a_r5_col_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && blk_mode && !col_en[0]) |=> mem[$past(slot0_addr)] == $past(slot_old[0]));
endmodule

// File: rtl/gfx_rdpipe.sv
module gfx_rdpipe #(
  parameter int DATA_W  = 16,
  parameter int MAX_LAT = 3,
  localparam int LAT_W = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [LAT_W-1:0]  lat,
  input  logic [DATA_W-1:0] issue_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              v_q  [MAX_LAT];
  logic [DATA_W-1:0] d_q  [MAX_LAT];
  logic              sh_v [MAX_LAT];
  logic [DATA_W-1:0] sh_d [MAX_LAT];
  logic              ins_hit [MAX_LAT];

  for (genvar s = 0; s < MAX_LAT; s++) begin : g_stage
    assign ins_hit[s] = issue && (int'(lat) == MAX_LAT - s);
    if (s == 0) begin : g_head
      assign sh_v[s] = 1'b0;
      assign sh_d[s] = '0;
    end else begin : g_body
      assign sh_v[s] = v_q[s-1];
      assign sh_d[s] = d_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < MAX_LAT; s++) begin
        v_q[s] <= 1'b0;
        d_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < MAX_LAT; s++) begin
        v_q[s] <= sh_v[s] | ins_hit[s];
        if (sh_v[s])         d_q[s] <= sh_d[s];
        else if (ins_hit[s]) d_q[s] <= issue_data;
      end
    end
  end

  assign out_valid = v_q[MAX_LAT-1];
  assign out_data  = d_q[MAX_LAT-1];

  // R6: a latency-1 read into a free output slot appears at the next edge
  a_r6_fast_read: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && lat == LAT_W'(1) && !v_q[MAX_LAT-2]) |=> (out_valid && out_data == $past(issue_data)));
endmodule

// File: rtl/gfx_gram.sv
module gfx_gram
  import gfx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int BLK_COLS  = 8,
  parameter int MAX_LAT   = 3,
  parameter int RESET_LAT = 2,
  localparam int NLANE = DATA_W / LANE_W,
  localparam int LAT_W = $clog2(MAX_LAT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_op,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic [NLANE-1:0]    cmd_lane_mask,
  input  logic                cmd_bitmask_en,
  input  logic [BLK_COLS-1:0] cmd_col_en,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] color_q;
  logic [DATA_W-1:0] mask_q;
  logic [LAT_W-1:0]  lat_q;
  logic              lat_ok;
  logic [DATA_W-1:0] rd_word;
  logic              is_wr;
  logic              is_fill;

  assign lat_ok  = (cmd_data != '0) && (cmd_data <= DATA_W'(MAX_LAT));
  assign is_wr   = (cmd_op == OP_WRITE) || (cmd_op == OP_FILL);
  assign is_fill = (cmd_op == OP_FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '1;
      mask_q  <= '1;
      lat_q   <= LAT_W'(RESET_LAT);
    end else begin
      if (cmd_op == OP_LDCOLOR)          color_q <= cmd_data;
      if (cmd_op == OP_LDMASK)           mask_q  <= cmd_data;
      if (cmd_op == OP_SETLAT && lat_ok) lat_q   <= LAT_W'(cmd_data);
    end
  end

  gfx_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .BLK_COLS(BLK_COLS)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (is_wr),
    .blk_mode    (is_fill),
    .wr_addr     (cmd_addr),
    .wr_data     (cmd_data),
    .color       (color_q),
    .lane_keep   (cmd_lane_mask),
    .bit_mask    (mask_q),
    .bit_mask_en (cmd_bitmask_en),
    .col_en      (cmd_col_en),
    .rd_addr     (cmd_addr),
    .rd_word     (rd_word)
  );

  gfx_rdpipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_rdpipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (cmd_op == OP_READ),
    .lat        (lat_q),
    .issue_data (rd_word),
    .out_valid  (rd_valid),
    .out_data   (rd_data)
  );

  // R7: the latency setting never leaves the legal range
  a_r7_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q != '0) && (int'(lat_q) <= MAX_LAT));
endmodule

// File: tb/gfx_gram_test.sv
`timescale 1ns/1ps
module gfx_gram_test;
  import gfx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic [1:0]  cmd_lane_mask;
  logic        cmd_bitmask_en;
  logic [7:0]  cmd_col_en;
  logic        rd_valid;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  gfx_gram uut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_lane_mask(cmd_lane_mask),
    .cmd_bitmask_en(cmd_bitmask_en), .cmd_col_en(cmd_col_en),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] m [256];
  logic [15:0] color_m;
  logic [15:0] mask_m;
  int lat_m;

  function automatic logic [15:0] pat(int a);
    return 16'(a * 40503) ^ 16'(a << 5);
  endfunction

  function automatic logic [15:0] mrg(logic [15:0] old, logic [15:0] nw,
                                      logic [1:0] lm, logic wpb);
    logic [15:0] en;
    en = {{8{~lm[1]}}, {8{~lm[0]}}};
    if (wpb) en = en & mask_m;
    return (old & ~en) | (nw & en);
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] a, logic [15:0] d,
                       logic [1:0] lm, logic wpb, logic [7:0] ce);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d;
    cmd_lane_mask = lm; cmd_bitmask_en = wpb; cmd_col_en = ce;
  endtask

  task automatic nop();
    issue(OP_NOP, 8'h00, 16'h0000, 2'b00, 1'b0, 8'h00);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, logic [1:0] lm, logic wpb);
    issue(OP_WRITE, a, d, lm, wpb, 8'h00);
    m[a] = mrg(m[a], d, lm, wpb);
  endtask

  task automatic fill(logic [7:0] a, logic [7:0] ce, logic [1:0] lm, logic wpb);
    issue(OP_FILL, a, 16'h0000, lm, wpb, ce);
    for (int i = 0; i < 8; i++)
      if (ce[i]) m[{a[7:3], 3'(i)}] = mrg(m[{a[7:3], 3'(i)}], color_m, lm, wpb);
  endtask

  task automatic ldc(logic [15:0] d);
    issue(OP_LDCOLOR, 8'h00, d, 2'b00, 1'b0, 8'h00);
    color_m = d;
  endtask

  task automatic ldm(logic [15:0] d);
    issue(OP_LDMASK, 8'h00, d, 2'b00, 1'b0, 8'h00);
    mask_m = d;
  endtask

  task automatic setlat(logic [15:0] v);
    issue(OP_SETLAT, 8'h00, v, 2'b00, 1'b0, 8'h00);
    if (v >= 1 && v <= 3) lat_m = int'(v);
  endtask

  // serial read: strobe must stay low until exactly lat_m cycles later
  task automatic rd_check(logic [7:0] a, string req);
    logic [15:0] exp;
    exp = m[a];
    issue(OP_READ, a, 16'h0000, 2'b00, 1'b0, 8'h00);
    for (int i = 1; i < lat_m; i++) begin
      nop();
      chk(rd_valid == 1'b0, req, 16'(rd_valid), 16'h0000);
    end
    nop();
    chk(rd_valid == 1'b1, req, 16'(rd_valid), 16'h0001);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_op = OP_NOP; cmd_addr = '0; cmd_data = '0;
    cmd_lane_mask = '0; cmd_bitmask_en = 1'b0; cmd_col_en = '0;
    for (int a = 0; a < 256; a++) m[a] = 16'h0000;
    color_m = 16'hFFFF; mask_m = 16'hFFFF; lat_m = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(rd_valid == 1'b0, "R1", 16'(rd_valid), 16'h0000);
    rd_check(8'h05, "R1");
    fill(8'h00, 8'h01, 2'b00, 1'b0);
    rd_check(8'h00, "R1");
    wr(8'h01, 16'h1234, 2'b00, 1'b1);
    rd_check(8'h01, "R1");

    // R2 and R6: full-array sweep at each latency
    for (int a = 0; a < 256; a++) wr(8'(a), pat(a), 2'b00, 1'b0);
    for (int l = 1; l <= 3; l++) begin
      setlat(16'(l));
      for (int a = 0; a < 256; a++) rd_check(8'(a), "R6");
    end

    // R3: every lane-mask pattern
    for (int a = 0; a < 64; a++) wr(8'(a), ~pat(a) ^ 16'h5A5A, 2'(a), 1'b0);
    for (int a = 0; a < 64; a++) rd_check(8'(a), "R3");

    // R4: bit mask applied and ignored, mixed with lane masks
    ldm(16'h0FF0);
    for (int a = 64; a < 128; a++)
      wr(8'(a), 16'(a * 977) ^ 16'hA55A, 2'(a >> 1), a[0]);
    for (int a = 64; a < 128; a++) rd_check(8'(a), "R4");

    // R5: group fill over every group, unaligned bases, one empty enable set
    ldc(16'hC3A5);
    ldm(16'hF00F);
    for (int g = 0; g < 32; g++)
      fill({5'(g), 3'(g)}, (g == 7) ? 8'h00 : 8'((g * 37 + 5) & 255),
           (g % 5 == 0) ? 2'b01 : 2'b00, g[2]);
    for (int a = 0; a < 256; a++) rd_check(8'(a), "R5");

    // R9: read immediately after write and after fill
    for (int a = 200; a < 216; a++) begin
      wr(8'(a), 16'(a) ^ 16'hBEEF, 2'b00, 1'b0);
      rd_check(8'(a), "R9");
    end
    ldc(16'h7E81);
    fill(8'hE5, 8'hFF, 2'b00, 1'b0);
    rd_check(8'hE3, "R9");

    // R7: illegal latency values ignored
    setlat(16'd2);
    setlat(16'd0);
    rd_check(8'h11, "R7");
    setlat(16'd7);
    rd_check(8'h12, "R7");
    setlat(16'd1);
    rd_check(8'h13, "R7");

    // R10: back-to-back reads at latency 2
    setlat(16'd2);
    for (int i = 0; i < 10; i++) begin
      if (i < 8) issue(OP_READ, 8'(40 + i), 16'h0000, 2'b00, 1'b0, 8'h00);
      else nop();
      if (i >= 2) begin
        chk(rd_valid == 1'b1, "R10", 16'(rd_valid), 16'h0001);
        chk(rd_data == m[40 + i - 2], "R10", rd_data, m[40 + i - 2]);
      end
    end
    nop(); nop();

    // R8: latency drop, results one cycle apart in order
    setlat(16'd3);
    issue(OP_READ, 8'd10, 16'h0000, 2'b00, 1'b0, 8'h00);
    setlat(16'd2);
    issue(OP_READ, 8'd11, 16'h0000, 2'b00, 1'b0, 8'h00);
    nop();
    chk(rd_valid == 1'b1 && rd_data == m[10], "R8", rd_data, m[10]);
    nop();
    chk(rd_valid == 1'b1 && rd_data == m[11], "R8", rd_data, m[11]);
    nop(); nop();

    // R8: collision, older read kept and newer dropped
    setlat(16'd3);
    issue(OP_READ, 8'd20, 16'h0000, 2'b00, 1'b0, 8'h00);
    setlat(16'd1);
    issue(OP_READ, 8'd21, 16'h0000, 2'b00, 1'b0, 8'h00);
    nop();
    chk(rd_valid == 1'b1 && rd_data == m[20], "R8", rd_data, m[20]);
    nop();
    chk(rd_valid == 1'b0, "R8", 16'(rd_valid), 16'h0000);
    nop(); nop();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule